// File: doc/BRIEF.md
# Multi-Step LFSR Random Word Generator

This block produces a new pseudo-random word on every enabled clock. The source is a Fibonacci linear feedback shift register of `WIDTH` bits whose taps are chosen by a parameter. The default is a 30-bit register with a maximal-length tap set. A plain register of this kind yields only one fresh bit per shift. Here the next-state logic applies the single shift `STEPS` times within one cycle, so each enabled clock gives `STEPS` new bits at once.

The word at the output is built from the register contents. An optional pair-swap mapping sits between the register and the word. It breaks up the "same value shifted by one" look that raw consecutive words would otherwise have. The word holds the low `STEPS` mapped bits, and every bit above them is zero.

The all-zero state locks the register up, so the block never loads it. Reset places the register at the all-ones seed. Each time an update brings the register back to the seed, the block raises a one-cycle `period_done` flag. A consumer can use that flag to count full periods of the sequence.

Top module: `lfsr_word_gen`

## Requirements
- R1: While `rst_n` is low, the register is all ones and `period_done` is 0. This takes effect at once, with no clock edge needed.
- R2: One single step moves every bit one place toward the MSB. The new bit 0 is the XOR of the register bits selected by the ones in `TAPS`. The default taps are bits 29, 5, 3 and 0.
- R3: Each rising edge with `en` high applies exactly `STEPS` single steps to the register.
- R4: A rising edge with `en` low leaves the register and `word` unchanged, and `period_done` stays 0.
- R5: The register never holds the all-zero value.
- R6: `word[i]` equals mapped bit `i` for `i < STEPS`. Every bit of `word` at or above `STEPS` is 0.
- R7: With `MAP_MODE` set to pair swap, register bits `4j` and `4j+1` trade places whenever both exist, and all other bits pass straight through. With straight mode, the mapping is the identity.
- R8: `period_done` is high for exactly one cycle. That cycle follows an enabled edge whose update left the register equal to the seed, and the register holds the seed during it.
- R9: With `WIDTH`=5, taps at bits 4 and 2 and `STEPS`=1, the register returns to the seed every 31 enabled cycles, and `period_done` does not fire in between.
- R10: Reset release is synchronised through two flops. After `rst_n` rises, the first two rising edges do not advance the register even with `en` high. The third rising edge advances it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Advance the register by `STEPS` shifts on this edge |
| word | output | WIDTH | Mapped random word, low `STEPS` bits valid, upper bits zero |
| period_done | output | 1 | One-cycle pulse when an update returns the register to the seed |

## Verification
Two events can land on the same or adjacent cycles: the return to the seed, and a drop of the enable.

- **Enable drop after a return.** The bench drives enabled cycles until the 5-bit instances hit the seed. It then pulls `en` low for several cycles. A behavioural model predicts the result: a single pulse, followed by a register held at the seed with no second pulse.
- **Enable gaps across a period.** A periodic enable pattern runs through several full periods. The bench counts enabled cycles between pulses and expects exactly 31 each time.
- **Release with enable high.** Reset is released while `en` is already high. This shows that the synchronised release holds off the first advance by two edges.

// File: rtl/lfsr_word_pkg.sv
package lfsr_word_pkg;

  // Output mapping variant between register and word.
  typedef enum logic {
    MAP_STRAIGHT  = 1'b0,
    MAP_PAIR_SWAP = 1'b1
  } map_mode_e;

  // Pairs (4j, 4j+1) are exchanged; pairs (4j+2, 4j+3) pass through.
  localparam int unsigned SWAP_GROUP = 4;

endpackage

// File: rtl/lfsr_rst_sync.sv
module lfsr_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= 2'b00;
    end else begin
      sync_q <= {sync_q[0], 1'b1};
    end
  end

  assign rst_sync_n = sync_q[1];

endmodule

// File: rtl/lfsr_step_unroll.sv
module lfsr_step_unroll #(
  parameter int unsigned          WIDTH = 30,
  parameter logic [WIDTH-1:0]     TAPS  = 30'h2000_0029,
  parameter int unsigned          STEPS = 8
) (
  input  logic [WIDTH-1:0] cur,
  output logic [WIDTH-1:0] nxt
);

  // Apply the single shift-and-feedback STEPS times in one cycle.
  always_comb begin
    logic [WIDTH-1:0] v;
    v = cur;
    for (int k = 0; k < int'(STEPS); k++) begin
      v = {v[WIDTH-2:0], ^(v & TAPS)};
    end
    nxt = v;
  end

endmodule

// File: rtl/lfsr_word_map.sv
module lfsr_word_map
  import lfsr_word_pkg::*;
#(
  parameter int unsigned WIDTH    = 30,
  parameter int unsigned STEPS    = 8,
  parameter map_mode_e   MAP_MODE = MAP_PAIR_SWAP
) (
  input  logic [WIDTH-1:0] state,
  output logic [WIDTH-1:0] word
);

  logic [WIDTH-1:0] mapped;

  for (genvar i = 0; i < int'(WIDTH); i++) begin : g_bit
    localparam int PARTNER = i ^ 1;
    localparam bit SWAP    = (MAP_MODE == MAP_PAIR_SWAP) &&
                             ((i % SWAP_GROUP) < 2) && (PARTNER < int'(WIDTH));
    localparam int SRC     = SWAP ? PARTNER : i;

    assign mapped[i] = state[SRC];

    if (i < int'(STEPS)) begin : g_live
      assign word[i] = mapped[i];
    end else begin : g_zero
      assign word[i] = 1'b0;
    end
  end

endmodule

// File: rtl/lfsr_word_gen.sv
module lfsr_word_gen
  import lfsr_word_pkg::*;
#(
  parameter int unsigned      WIDTH    = 30,
  parameter logic [WIDTH-1:0] TAPS     = 30'h2000_0029,
  parameter int unsigned      STEPS    = 8,
  parameter map_mode_e        MAP_MODE = MAP_PAIR_SWAP
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  output logic [WIDTH-1:0] word,
  output logic             period_done
);

  localparam logic [WIDTH-1:0] SEED = {WIDTH{1'b1}};

  logic             rst_sync_n;
  logic [WIDTH-1:0] state_q;
  logic [WIDTH-1:0] state_d;
  logic [WIDTH-1:0] step_nxt;
  logic             done_d;

  lfsr_rst_sync u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  lfsr_step_unroll #(
    .WIDTH (WIDTH),
    .TAPS  (TAPS),
    .STEPS (STEPS)
  ) u_step (
    .cur (state_q),
    .nxt (step_nxt)
  );

  // Next-state process
  always_comb begin
    state_d = state_q;
    done_d  = 1'b0;
    if (en) begin
      state_d = step_nxt;
      done_d  = (step_nxt == SEED);
    end
  end

  // Register process
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      state_q     <= SEED;
      period_done <= 1'b0;
    end else begin
      state_q     <= state_d;
      period_done <= done_d;
    end
  end

  lfsr_word_map #(
    .WIDTH    (WIDTH),
    .STEPS    (STEPS),
    .MAP_MODE (MAP_MODE)
  ) u_map (
    .state (state_q),
    .word  (word)
  );

endmodule

// File: rtl/lfsr_word_gen_chk.sv
module lfsr_word_gen_chk #(
  parameter int unsigned WIDTH = 30
) (
  input logic             clk,
  input logic             rst_n,
  input logic             en,
  input logic [WIDTH-1:0] state,
  input logic             period_done
);

  localparam logic [WIDTH-1:0] SEED = {WIDTH{1'b1}};

  assert_state_nonzero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    state != '0);

  assert_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> ($stable(state) && !period_done));

  assert_seed_at_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    period_done |-> (state == SEED));

  assert_pulse_after_enable_R8: assert property (@(posedge clk) disable iff (!rst_n)
    period_done |-> $past(en));

endmodule

bind lfsr_word_gen lfsr_word_gen_chk #(.WIDTH(WIDTH)) u_chk (
  .clk         (clk),
  .rst_n       (rst_sync_n),
  .en          (en),
  .state       (state_q),
  .period_done (period_done)
);

// File: tb/tb_lfsr_word_gen.sv
module tb_lfsr_word_gen;
  import lfsr_word_pkg::*;

  logic clk;
  logic rst_n;
  logic en;

  logic [29:0] w0;
  logic        d0;
  logic [4:0]  w1;
  logic        d1;
  logic [4:0]  w2;
  logic        d2;

  int checks;
  int errors;
  bit finished;

  initial clk = 1'b0;
  always #2 clk = ~clk;

  lfsr_word_gen #(.WIDTH(30), .TAPS(30'h2000_0029), .STEPS(30), .MAP_MODE(MAP_PAIR_SWAP))
    dut (.clk(clk), .rst_n(rst_n), .en(en), .word(w0), .period_done(d0));

  lfsr_word_gen #(.WIDTH(5), .TAPS(5'b10100), .STEPS(1), .MAP_MODE(MAP_STRAIGHT))
    dut_p1 (.clk(clk), .rst_n(rst_n), .en(en), .word(w1), .period_done(d1));

  lfsr_word_gen #(.WIDTH(5), .TAPS(5'b10100), .STEPS(3), .MAP_MODE(MAP_PAIR_SWAP))
    dut_p3 (.clk(clk), .rst_n(rst_n), .en(en), .word(w2), .period_done(d2));

  // Reference model state
  logic [31:0] m0, m1, m2;
  logic        e0, e1, e2;
  int          settle;
  int          en_count;

  function automatic logic [31:0] mask_of(int w);
    return (w >= 32) ? 32'hFFFF_FFFF : ((32'd1 << w) - 32'd1);
  endfunction

  function automatic logic [31:0] adv(logic [31:0] s, int w, logic [31:0] taps, int n);
    logic [31:0] r;
    r = s;
    for (int k = 0; k < n; k++) begin
      r = ((r << 1) | {31'd0, ^(r & taps)}) & mask_of(w);
    end
    return r;
  endfunction

  function automatic logic [31:0] wmap(logic [31:0] s, int w, bit swap, int n);
    logic [31:0] r;
    r = '0;
    for (int i = 0; i < w; i++) begin
      int src;
      src = i;
      if (swap && (i % 4) < 2 && (i ^ 1) < w) src = i ^ 1;
      r[i] = s[src];
    end
    return r & mask_of(n);
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    check("R3 R6 R7 word 30b", {2'b0, w0}, wmap(m0, 30, 1'b1, 30));
    check("R8 pulse 30b", {31'd0, d0}, {31'd0, e0});
    check("R5 nonzero 30b", {31'd0, (w0 != '0)}, 32'd1);
    check("R2 R6 word 5b step1", {27'd0, w1}, wmap(m1, 5, 1'b0, 1));
    check("R8 R9 pulse 5b step1", {31'd0, d1}, {31'd0, e1});
    check("R3 R7 word 5b step3", {27'd0, w2}, wmap(m2, 5, 1'b1, 3));
    check("R8 pulse 5b step3", {31'd0, d2}, {31'd0, e2});
  endtask

  // Drive en after a negedge, let one posedge pass, compare at the next negedge.
  task automatic run_cycle(logic e);
    en = e;
    @(posedge clk);
    e0 = 1'b0; e1 = 1'b0; e2 = 1'b0;
    if (settle > 0) begin
      settle--;
    end else if (e) begin
      m0 = adv(m0, 30, 32'h2000_0029, 30);
      m1 = adv(m1, 5, 32'h14, 1);
      m2 = adv(m2, 5, 32'h14, 3);
      e0 = (m0 == mask_of(30));
      e1 = (m1 == mask_of(5));
      e2 = (m2 == mask_of(5));
      en_count++;
    end
    @(negedge clk);
    compare_all();
    if (d1) begin
      check("R9 enabled cycles per period", en_count, 32'd31);
      en_count = 0;
    end
  endtask

  task automatic model_reset();
    m0 = mask_of(30); m1 = mask_of(5); m2 = mask_of(5);
    e0 = 1'b0; e1 = 1'b0; e2 = 1'b0;
    settle = 2;
    en_count = 0;
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    checks = 0; errors = 0; finished = 1'b0;
    rst_n = 1'b0;
    en = 1'b0;
    model_reset();
    repeat (3) @(negedge clk);
    // R1: reset state
    compare_all();
    check("R1 reset word 30b", {2'b0, w0}, {2'b0, 30'h3FFF_FFFF});
    check("R1 reset pulse", {31'd0, d0}, 32'd0);

    // R10: release with en high; two edges without advance
    rst_n = 1'b1;
    run_cycle(1'b1);
    check("R10 hold after edge 1", {27'd0, w1}, 32'd1);
    run_cycle(1'b1);
    check("R10 hold after edge 2", {2'b0, w0}, {2'b0, 30'h3FFF_FFFF});
    run_cycle(1'b1);
    check("R10 advance on edge 3", {31'd0, (m1 != mask_of(5))}, 32'd1);

    // Free run across two 5-bit periods
    for (int i = 0; i < 70; i++) run_cycle(1'b1);

    // Return to seed then drop enable in the following cycles (R4, R8)
    while (m1 != mask_of(5)) run_cycle(1'b1);
    check("R8 pulse on seed return", {31'd0, d1}, 32'd1);
    for (int i = 0; i < 3; i++) begin
      run_cycle(1'b0);
      check("R4 held at seed, no pulse", {31'd0, d1}, 32'd0);
    end

    // Gapped enable across several periods (R4, R9)
    for (int i = 0; i < 120; i++) run_cycle((i % 3) != 0);

    // R1: asynchronous reset mid-cycle, no clock edge
    #1 rst_n = 1'b0;
    #0.5;
    check("R1 async reset word 30b", {2'b0, w0}, wmap(32'h3FFF_FFFF, 30, 1'b1, 30));
    check("R1 async reset word 5b", {27'd0, w1}, 32'd1);
    check("R1 async reset pulse", {31'd0, d2}, 32'd0);
    model_reset();
    @(negedge clk);
    rst_n = 1'b1;
    for (int i = 0; i < 40; i++) run_cycle(1'b1);

    finish_run();
  end

endmodule